// File: doc/BRIEF.md
# Trimmed One-Second Prescaler

This block turns a 32,768 Hz reference, presented as a single-cycle enable on the system clock, into a one-second tick for a seconds/minutes/hours counter. The tick is a one-cycle pulse. A second normally spans 32,768 enabled edges. Only three seconds per minute are corrected: the ones whose BCD seconds value is 00, 20 or 40. Each of those is stretched or shrunk by an even number of reference edges, taken from a 7-bit trim code held in the block. One step equals 2 edges per 20 seconds, which is roughly 3.05 ppm.

The trim code is loaded through a write strobe and cleared when the oscillator-stop input is raised. The amount applied to a second is captured when that second begins. A write made during a second therefore only affects later seconds. The block also produces 1 Hz and 2 Hz square waves for pulse-style interrupts. These waves follow the same count, so any correction only lengthens or shortens their final low phase. The crystal oscillator and the way the trim code is chosen are outside this block.

Top module: `trimmed_second_prescaler`

## Requirements
- R1: A second whose `sec_bcd` is not 8'h00, 8'h20 or 8'h40 lasts exactly BASE_CYCLES enabled edges, whatever the trim code. The default BASE_CYCLES is 32768, and it must be a power of two.
- R2: In a second whose `sec_bcd` is 8'h00, 8'h20 or 8'h40, a trim code with bit 6 clear and bits 5:1 not all zero lengthens the second by 2*(code[5:0]-1) edges. Examples: 7'b0000111 gives +12, and 7'b0111111 gives +124.
- R3: In those same seconds, a code with bit 6 set and bits 5:1 not all zero shortens the second by 2*((~code)+1) edges, where the inversion covers all 7 bits. Examples: 7'b1111110 gives -4, and 7'b1000010 gives -124.
- R4: When code bits 5:1 are all zero, no correction is applied, whatever bits 6 and 0 hold. Examples: 7'b0000000, 7'b0000001 and 7'b1000001.
- R5: The correction used for a second comes from the code held at the start of that second. A write (`trim_wr` high with `trim_code`) made at any point inside a second takes effect only from the next second on.
- R6: A cycle with `osc_stop` high clears the stored code to zero. It wins over a write made in the same cycle, and later 00/20/40 seconds then run untrimmed.
- R7: `tick_o` is high for exactly one cycle. That cycle follows the edge that completes a second. Cycles with `ref_en` low advance nothing: no tick is raised and the waves hold their level.
- R8: Let p be the count of enabled edges since the second began. `wave_o[0]` (1 Hz) is high for p < BASE/2 and low otherwise. `wave_o[1]` (2 Hz) is high for p < BASE/4 and for BASE/2 <= p < 3*BASE/4, and low otherwise. Any correction therefore only changes the last low phase.
- R9: While `rst` is high and right after it, `tick_o` is 0, `wave_o` is 2'b11 and the stored code is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | 1 | One enable per 32,768 Hz reference period |
| trim_wr | input | 1 | Loads `trim_code` into the stored trim code |
| trim_code | input | 7 | Trim code to store |
| sec_bcd | input | 8 | Current BCD seconds value of the time counter |
| osc_stop | input | 1 | Oscillator-stop flag; clears the stored code |
| tick_o | output | 1 | One-cycle pulse at the end of each second |
| wave_o | output | 2 | Square waves: bit 0 is 1 Hz, bit 1 is 2 Hz |

## Verification
A corrupted position counter shows at the ports within one enabled edge, because both waves are decoded straight from it. A wrong captured correction only shows when the tick arrives, so it can go unseen for up to one second and only in a 00/20/40 second. A corrupted stored code can stay hidden for up to 20 seconds, until the next corrected second begins. For that reason the bench measures every tick-to-tick interval in enabled edges, and it checks the wave shape on every cycle.

// File: rtl/tsp_pkg.sv
package tsp_pkg;

    localparam int TRIM_W  = 7;
    localparam int SEC_W   = 8;
    localparam int ADJ_W   = 7;
    localparam int MAX_ADJ = 124;

    typedef logic [TRIM_W-1:0] trim_code_t;
    typedef logic [SEC_W-1:0]  sec_bcd_t;

    // Decoded correction for one second: enable, direction, size in edges.
    typedef struct packed {
        logic             active;
        logic             shrink;
        logic [ADJ_W-1:0] cycles;
    } trim_adj_t;

    function automatic trim_adj_t decode_trim(trim_code_t code);
        trim_adj_t  res;
        logic [5:0] steps;
        if (code[6]) begin
            steps = (~code[5:0]) + 6'd1;
        end else begin
            steps = code[5:0] - 6'd1;
        end
        res.active = |code[5:1];
        res.shrink = code[6];
        res.cycles = {steps, 1'b0};
        if (!res.active) begin
            res = '0;
        end
        return res;
    endfunction

    function automatic logic is_trim_second(sec_bcd_t s);
        return (s == 8'h00) || (s == 8'h20) || (s == 8'h40);
    endfunction

endpackage

// File: rtl/tsp_trim_store.sv
module tsp_trim_store
    import tsp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       stop_i,
    input  logic       wr_i,
    input  trim_code_t code_i,
    output trim_code_t code_o
);

    trim_code_t code_q;

    // Oscillator stop outranks a write landing in the same cycle.
    always_ff @(posedge clk) begin
        if (rst || stop_i) begin
            code_q <= '0;
        end else if (wr_i) begin
            code_q <= code_i;
        end
    end

    assign code_o = code_q;

endmodule

// File: rtl/tsp_length_sel.sv
module tsp_length_sel
    import tsp_pkg::*;
#(
    parameter int BASE_CYCLES = 32768,
    parameter int CNT_W       = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  trim_code_t       code_i,
    input  sec_bcd_t         sec_i,
    output logic [CNT_W-1:0] last_o
);

    localparam logic [CNT_W-1:0] BASE_LAST = CNT_W'(BASE_CYCLES - 1);

    trim_adj_t adj_q;

    // Captured at each second boundary so mid-second writes wait a second.
    always_ff @(posedge clk) begin
        if (rst) begin
            adj_q <= '0;
        end else if (load_i) begin
            adj_q <= decode_trim(code_i);
        end
    end

    always_comb begin
        last_o = BASE_LAST;
        if (is_trim_second(sec_i) && adj_q.active) begin
            if (adj_q.shrink) begin
                last_o = BASE_LAST - CNT_W'(adj_q.cycles);
            end else begin
                last_o = BASE_LAST + CNT_W'(adj_q.cycles);
            end
        end
    end

endmodule

// File: rtl/tsp_sec_counter.sv
module tsp_sec_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic [CNT_W-1:0] last_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o,
    output logic             tick_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             tick_q;
    logic             wrap;

    // Compare with >= so a late change of the limit never lets the count run away.
    assign wrap = en_i && (cnt_q >= last_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= wrap;
            if (wrap) begin
                cnt_q <= '0;
            end else if (en_i) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = wrap;
    assign tick_o = tick_q;

endmodule

// File: rtl/tsp_wave_gen.sv
module tsp_wave_gen #(
    parameter int BASE_CYCLES = 32768,
    parameter int CNT_W       = 16,
    parameter int WAVES       = 2
) (
    input  logic [CNT_W-1:0] cnt_i,
    output logic [WAVES-1:0] wave_o
);

    localparam int LOG_BASE = $clog2(BASE_CYCLES);
    localparam logic [CNT_W-1:0] BASE_V = CNT_W'(BASE_CYCLES);

    logic in_base;
    assign in_base = cnt_i < BASE_V;

    // Wave k runs at 2^k Hz; anything past the nominal length stays low.
    for (genvar k = 0; k < WAVES; k++) begin : g_wave
        assign wave_o[k] = in_base && !cnt_i[LOG_BASE-1-k];
    end

endmodule

// File: rtl/trimmed_second_prescaler.sv
module trimmed_second_prescaler
    import tsp_pkg::*;
#(
    parameter int BASE_CYCLES = 32768
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_en,
    input  logic       trim_wr,
    input  logic [6:0] trim_code,
    input  logic [7:0] sec_bcd,
    input  logic       osc_stop,
    output logic       tick_o,
    output logic [1:0] wave_o
);

    localparam int CNT_W = $clog2(BASE_CYCLES + MAX_ADJ + 1);
    localparam int WAVES = 2;

    trim_code_t       trim_q;
    logic [CNT_W-1:0] last;
    logic [CNT_W-1:0] cnt;
    logic             wrap;

    tsp_trim_store u_store (
        .clk    (clk),
        .rst    (rst),
        .stop_i (osc_stop),
        .wr_i   (trim_wr),
        .code_i (trim_code),
        .code_o (trim_q)
    );

    tsp_length_sel #(
        .BASE_CYCLES (BASE_CYCLES),
        .CNT_W       (CNT_W)
    ) u_len (
        .clk    (clk),
        .rst    (rst),
        .load_i (wrap),
        .code_i (trim_q),
        .sec_i  (sec_bcd),
        .last_o (last)
    );

    tsp_sec_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .en_i   (ref_en),
        .last_i (last),
        .cnt_o  (cnt),
        .wrap_o (wrap),
        .tick_o (tick_o)
    );

    tsp_wave_gen #(
        .BASE_CYCLES (BASE_CYCLES),
        .CNT_W       (CNT_W),
        .WAVES       (WAVES)
    ) u_wave (
        .cnt_i  (cnt),
        .wave_o (wave_o)
    );

endmodule

// File: rtl/tsp_checker.sv
module tsp_checker #(
    parameter int BASE_CYCLES = 32768
) (
    input logic       clk,
    input logic       rst,
    input logic       ref_en,
    input logic       trim_wr,
    input logic [6:0] trim_code,
    input logic       osc_stop,
    input logic [6:0] trim_q,
    input logic       tick_o,
    input logic [1:0] wave_o
);

    localparam int SPAN = 124;

    int unsigned run;

    // Enabled edges since the last tick, counted independently of the design.
    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 0;
        end else if (tick_o) begin
            run <= ref_en ? 1 : 0;
        end else if (ref_en) begin
            run <= run + 1;
        end
    end

    a_r7_tick_one_cycle: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);

    a_r7_tick_needs_enable: assert property (@(posedge clk) disable iff (rst)
        tick_o |-> $past(ref_en));

    a_r7_idle_freeze: assert property (@(posedge clk) disable iff (rst)
        !ref_en |=> (!tick_o && $stable(wave_o)));

    a_r8_waves_high_at_start: assert property (@(posedge clk) disable iff (rst)
        tick_o |-> (wave_o == 2'b11));

    a_r6_stop_clears: assert property (@(posedge clk) disable iff (rst)
        $past(osc_stop) |-> (trim_q == 7'd0));

    a_r5_write_lands: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && trim_wr && !osc_stop) |-> (trim_q == $past(trim_code)));

    // R2 and R3: every second stays inside the correction window
    a_r2_len_window: assert property (@(posedge clk) disable iff (rst)
        tick_o |-> ((run >= BASE_CYCLES - SPAN) && (run <= BASE_CYCLES + SPAN)));

endmodule

bind trimmed_second_prescaler tsp_checker #(
    .BASE_CYCLES (BASE_CYCLES)
) u_tsp_chk (
    .clk       (clk),
    .rst       (rst),
    .ref_en    (ref_en),
    .trim_wr   (trim_wr),
    .trim_code (trim_code),
    .osc_stop  (osc_stop),
    .trim_q    (trim_q),
    .tick_o    (tick_o),
    .wave_o    (wave_o)
);

// File: tb/trimmed_second_prescaler_bench.sv
module trimmed_second_prescaler_bench;

    localparam int N = 1024;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_en = 1'b0;
    logic       trim_wr = 1'b0;
    logic       osc_stop = 1'b0;
    logic [6:0] trim_code = '0;
    logic [7:0] sec_bcd = 8'h01;
    logic       tick;
    logic [1:0] wave;

    always #2 clk = ~clk;

    trimmed_second_prescaler #(.BASE_CYCLES(N)) u_trimmed_second_prescaler (
        .clk       (clk),
        .rst       (rst),
        .ref_en    (ref_en),
        .trim_wr   (trim_wr),
        .trim_code (trim_code),
        .sec_bcd   (sec_bcd),
        .osc_stop  (osc_stop),
        .tick_o    (tick),
        .wave_o    (wave)
    );

    int         checks = 0;
    int         bad = 0;
    int         ecount = 0;
    int         total_cyc = 0;
    int         got_len = 0;
    logic [6:0] model_trim = '0;
    bit         tick_seen = 0;
    bit         prev_tick = 0;
    bit         wave_bad = 0;
    bit         aborted = 0;

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_len(logic [6:0] c, logic [7:0] s);
        int d = 0;
        if ((s == 8'h00 || s == 8'h20 || s == 8'h40) && (c[5:1] != 5'd0)) begin
            if (c[6]) d = -2 * (int'({1'b0, ~c[5:0]}) + 1);
            else      d = 2 * (int'(c[5:0]) - 1);
        end
        return N + d;
    endfunction

    task automatic cyc();
        bit e1, e2;
        @(posedge clk);
        if (ref_en) ecount++;
        total_cyc++;
        @(negedge clk);
        if (tick) begin
            if (prev_tick) check(1'b0, "R7 tick longer than one cycle", 1, 0);
            got_len   = ecount;
            ecount    = 0;
            tick_seen = 1;
        end
        prev_tick = tick;
        e1 = ecount < N/2;
        e2 = (ecount < N/4) || (ecount >= N/2 && ecount < N/2 + N/4);
        if (wave !== {e2, e1}) wave_bad = 1;
    endtask

    task automatic run_second(logic [7:0] s, int en_pct, int wpos, bit wr,
                              logic [6:0] wc, bit stp, string req);
        int exp;
        int k;
        exp       = exp_len(model_trim, s);
        sec_bcd   = s;
        tick_seen = 0;
        wave_bad  = 0;
        k         = 0;
        while (!tick_seen && !aborted) begin
            ref_en    = (($urandom % 100) < en_pct);
            trim_wr   = wr && (k == wpos);
            osc_stop  = stp && (k == wpos);
            trim_code = wc;
            if (k == wpos) begin
                if (stp) model_trim = '0;
                else if (wr) model_trim = wc;
            end
            cyc();
            k++;
            if (k > 8*N || total_cyc > 190000) begin
                aborted = 1;
                check(1'b0, "watchdog expired", k, exp);
            end
        end
        trim_wr  = 0;
        osc_stop = 0;
        if (!aborted) begin
            check(got_len == exp, req, got_len, exp);
            check(!wave_bad, "R8 wave shape within second", int'(wave_bad), 0);
        end
    endtask

    initial begin
        void'($urandom(32'd7741));
        rst    = 1;
        ref_en = 1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i > 0) check(tick == 1'b0, "R9 tick low in reset", int'(tick), 0);
        end
        check(wave == 2'b11, "R9 waves high after reset", int'(wave), 3);
        rst    = 0;
        ecount = 0;

        // R1: plain second, default code
        run_second(8'h05, 100, -1, 0, 7'd0, 0, "R1 untrimmed second");
        // R5: write at start of a second does not touch that second
        run_second(8'h00, 100, 0, 1, 7'b0000111, 0, "R5 write waits for next second");
        // R2: lengthen on 00, 20, 40
        run_second(8'h00, 100, -1, 0, 7'd0, 0, "R2 +12 at sec 00");
        run_second(8'h20, 100, -1, 0, 7'd0, 0, "R2 +12 at sec 20");
        run_second(8'h40, 100, -1, 0, 7'd0, 0, "R2 +12 at sec 40");
        // R1: other seconds ignore the code
        run_second(8'h10, 100, -1, 0, 7'd0, 0, "R1 sec 10 untrimmed");
        run_second(8'h59, 100, 0, 1, 7'b0000001, 0, "R1 sec 59 untrimmed");
        // R4: dead zone codes
        run_second(8'h00, 100, 0, 1, 7'b1111110, 0, "R4 code 0000001 no change");
        // R3: shrink by 4
        run_second(8'h00, 100, 0, 1, 7'b0000000, 0, "R3 code 1111110 gives -4");
        run_second(8'h20, 100, 0, 1, 7'b1000001, 0, "R4 code 0000000 no change");
        run_second(8'h40, 100, 0, 1, 7'b1000010, 0, "R4 code 1000001 no change");
        run_second(8'h00, 100, 0, 1, 7'b0111111, 0, "R3 code 1000010 gives -124");
        run_second(8'h00, 100, -1, 0, 7'd0, 0, "R2 code 0111111 gives +124");
        // R5: mid-second write keeps the current second
        run_second(8'h20, 100, N/3, 1, 7'b0000111, 0, "R5 mid-second write ignored now");
        run_second(8'h40, 100, -1, 0, 7'd0, 0, "R5 mid-second write applied next");
        // R6: stop with a write in the same cycle clears the code
        run_second(8'h00, 100, N/4, 1, 7'b0111111, 1, "R6 current second keeps capture");
        run_second(8'h20, 100, -1, 0, 7'd0, 0, "R6 stop beats write, untrimmed");
        run_second(8'h31, 100, 0, 1, 7'b1111110, 0, "R1 untrimmed after load");
        run_second(8'h00, 100, 0, 0, 7'd0, 1, "R3 -4 before stop lands");
        run_second(8'h40, 100, -1, 0, 7'd0, 0, "R6 stop alone clears code");
        // R7: gated reference counts only enabled edges
        run_second(8'h11, 100, 0, 1, 7'b1111110, 0, "R7 setup second");
        run_second(8'h00, 50, -1, 0, 7'd0, 0, "R7 gated enable, -4 second");
        run_second(8'h27, 30, -1, 0, 7'd0, 0, "R7 sparse enable, plain second");

        // Random seconds mixed with trimmed ones
        for (int i = 0; i < 30 && !aborted; i++) begin
            logic [7:0] s;
            case ($urandom % 5)
                0: s = 8'h00;
                1: s = 8'h20;
                2: s = 8'h40;
                default: s = {4'($urandom % 6), 4'($urandom % 10)};
            endcase
            run_second(s, (($urandom % 2) != 0) ? 100 : 60, int'($urandom % (N/2)),
                       ($urandom % 2) != 0, 7'($urandom), ($urandom % 8) == 0,
                       "R2 R3 random second length");
        end

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule